// File: doc/BRIEF.md
# ISA Clock Divider and I/O Recovery Timer

This block sits in the PCI clock domain of a PCI-to-ISA bridge. It produces a single-cycle clock enable that marks each ISA bus clock period. The period is derived from the PCI clock through a 3-bit divisor code. Code `010` selects divide-by-three. Every other code selects divide-by-four: `011` is the defined setting, and the remaining codes are invalid but fall back to it, so the enable never stops.

It also enforces a quiet gap after each ISA I/O cycle before the cycle engine may start the next one. The gap has two parts: a fixed one-clock delay that is always present, and a programmable part of `n+1` clocks, where `n` is a 4-bit code. There are separate codes for 8-bit and 16-bit cycles, and the width of the cycle that just finished selects which code applies. The grant output stays low for the whole gap. Completions of cycles that are not I/O cycles leave the gap logic untouched.

Top module: `isa_clk_recovery`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to idle: after that edge `io_grant` is 1 and `isa_clk_en` is 0.
- R2: With `div_sel` = 3'b010, `isa_clk_en` pulses once every 3 clocks.
- R3: With `div_sel` = 3'b011, `isa_clk_en` pulses once every 4 clocks.
- R4: Any other `div_sel` value (000, 001, 100 to 111) gives the same 4-clock period as 3'b011.
- R5: `isa_clk_en` is never high for two consecutive clocks.
- R6: An I/O completion (`cyc_done`=1 and `cyc_is_io`=1 at an edge) with `cyc_wide`=0 drops `io_grant` after that edge. `io_grant` then stays low for exactly `rec8_code`+2 clocks, that is `rec8_code`+1 clocks of recovery plus the fixed clock.
- R7: An I/O completion with `cyc_wide`=1 holds `io_grant` low for exactly `rec16_code`+2 clocks.
- R8: Code 4'b0000 gives the shortest gap, 2 clocks. Code 4'b1111 gives the longest, 17 clocks.
- R9: A completion with `cyc_is_io`=0 does not change `io_grant` and does not change the remaining gap.
- R10: An I/O completion that arrives during a gap restarts the gap, using the setting for the new cycle's width.
- R11: Once high, `io_grant` stays high until the next I/O completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Synchronous active-low reset |
| div_sel | input | 3 | ISA clock divisor code |
| rec8_code | input | 4 | Recovery code for 8-bit I/O cycles |
| rec16_code | input | 4 | Recovery code for 16-bit I/O cycles |
| cyc_done | input | 1 | A bus cycle completes this clock |
| cyc_is_io | input | 1 | The completing cycle is an I/O cycle |
| cyc_wide | input | 1 | The completing cycle is 16-bit (1) or 8-bit (0) |
| isa_clk_en | output | 1 | One-clock pulse per ISA clock period |
| io_grant | output | 1 | The next I/O cycle may start |

## Verification
The bench builds the block with its default parameters: a 3-bit divisor code, 4-bit recovery codes and a one-clock fixed delay. With these values every divisor code, including all six invalid ones, can be driven, and every recovery code from the 2-clock minimum to the 17-clock maximum can be reached within a short run. Random widths and codes are mixed with directed cases. These cover restarting a gap in the middle with the other width, completions of non-I/O cycles during a gap, and a reset that arrives while a gap is running.

// File: rtl/isa_tmr_pkg.sv
// Package: shared constants and helpers for the ISA clock divider and
// I/O recovery timer. Assumes divisor and code widths match the top's
// parameter defaults when the helpers are used.
package isa_tmr_pkg;

    localparam int FAST_RATIO_DEF = 3;
    localparam int SLOW_RATIO_DEF = 4;
    localparam logic [2:0] FAST_CODE_DEF = 3'b010;

    // Largest of two ratios, used to size the phase counter.
    function automatic int max_ratio(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/isa_clk_div.sv
// Module: isa_clk_div
// Emits a one-clock enable every FAST_RATIO clocks when div_sel equals
// FAST_CODE, otherwise every SLOW_RATIO clocks (invalid codes fall back
// to the slow ratio). Assumes both ratios are at least 2.
module isa_clk_div
    import isa_tmr_pkg::*;
#(
    parameter int DIV_W = 3,
    parameter logic [DIV_W-1:0] FAST_CODE = DIV_W'(FAST_CODE_DEF),
    parameter int FAST_RATIO = FAST_RATIO_DEF,
    parameter int SLOW_RATIO = SLOW_RATIO_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_sel,
    output logic             clk_en
);
    localparam int TOP_RATIO = max_ratio(FAST_RATIO, SLOW_RATIO);
    localparam int PH_W = $clog2(TOP_RATIO + 1);

    logic [PH_W-1:0] phase;
    logic [PH_W-1:0] last_ph;

    // Pick the terminal phase for the selected ratio.
    always_comb begin
        if (div_sel == FAST_CODE) last_ph = PH_W'(FAST_RATIO - 1);
        else                      last_ph = PH_W'(SLOW_RATIO - 1);
    end

    // Phase counter that wraps at (or past) the terminal phase.
    always_ff @(posedge clk) begin
        if (!rst_n)                phase <= '0;
        else if (phase >= last_ph) phase <= '0;
        else                       phase <= phase + 1'b1;
    end

    assign clk_en = (phase >= last_ph);
endmodule

// File: rtl/io_recovery_timer.sv
// Module: io_recovery_timer
// On start, loads code+1+FIXED_DLY from the code for the cycle's width,
// then counts down; grant is high only when the count is zero.
// Assumes start marks completion of an I/O cycle only.
module io_recovery_timer #(
    parameter int CODE_W    = 4,
    parameter int FIXED_DLY = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              wide,
    input  logic [CODE_W-1:0] code8,
    input  logic [CODE_W-1:0] code16,
    output logic              grant
);
    localparam int CNT_MAX = (1 << CODE_W) + FIXED_DLY;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    logic [CNT_W-1:0]  count;
    logic [CODE_W-1:0] sel_code;
    logic [CNT_W-1:0]  load_val;

    // Choose the setting for the finishing cycle's width, add the offsets.
    always_comb begin
        sel_code = wide ? code16 : code8;
        load_val = CNT_W'(sel_code) + CNT_W'(1 + FIXED_DLY);
    end

    // Gap counter: reload on start, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)        count <= '0;
        else if (start)    count <= load_val;
        else if (count != '0) count <= count - 1'b1;
    end

    assign grant = (count == '0);
endmodule

// File: rtl/isa_clk_recovery.sv
// Module: isa_clk_recovery (top)
// ISA clock enable generator plus I/O back-to-back recovery gate.
// Assumes one cycle completion is reported per clock at most.
module isa_clk_recovery #(
    parameter int DIV_W     = 3,
    parameter int CODE_W    = 4,
    parameter int FIXED_DLY = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div_sel,
    input  logic [CODE_W-1:0] rec8_code,
    input  logic [CODE_W-1:0] rec16_code,
    input  logic              cyc_done,
    input  logic              cyc_is_io,
    input  logic              cyc_wide,
    output logic              isa_clk_en,
    output logic              io_grant
);
    logic io_end;

    // Only finished I/O cycles open a recovery gap.
    always_comb io_end = cyc_done & cyc_is_io;

    isa_clk_div #(
        .DIV_W(DIV_W)
    ) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .div_sel(div_sel),
        .clk_en (isa_clk_en)
    );

    io_recovery_timer #(
        .CODE_W   (CODE_W),
        .FIXED_DLY(FIXED_DLY)
    ) u_rec (
        .clk   (clk),
        .rst_n (rst_n),
        .start (io_end),
        .wide  (cyc_wide),
        .code8 (rec8_code),
        .code16(rec16_code),
        .grant (io_grant)
    );
endmodule

// File: rtl/isa_clk_recovery_chk.sv
// Module: isa_clk_recovery_chk
// Port-level properties of isa_clk_recovery, bound to every instance.
module isa_clk_recovery_chk (
    input logic clk,
    input logic rst_n,
    input logic cyc_done,
    input logic cyc_is_io,
    input logic isa_clk_en,
    input logic io_grant
);
    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !$past(rst_n)) |-> (io_grant && !isa_clk_en));

    // R5
    en_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        isa_clk_en |=> !isa_clk_en);

    // R2
    en_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        isa_clk_en |=> !isa_clk_en ##1 !isa_clk_en);

    // R8
    min_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_done && cyc_is_io) |=> !io_grant ##1 !io_grant);

    // R9
    non_io_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_grant && cyc_done && !cyc_is_io) |=> io_grant);

    // R11
    grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_grant && !(cyc_done && cyc_is_io)) |=> io_grant);

    // R10
    no_rise_on_io_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(io_grant) |-> !$past(cyc_done && cyc_is_io));
endmodule

bind isa_clk_recovery isa_clk_recovery_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cyc_done  (cyc_done),
    .cyc_is_io (cyc_is_io),
    .isa_clk_en(isa_clk_en),
    .io_grant  (io_grant)
);

// File: tb/sim_isa_clk_recovery.sv
module sim_isa_clk_recovery;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] div_sel = 3'b011;
    logic [3:0] rec8_code = '0;
    logic [3:0] rec16_code = '0;
    logic       cyc_done = 1'b0;
    logic       cyc_is_io = 1'b0;
    logic       cyc_wide = 1'b0;
    logic       isa_clk_en;
    logic       io_grant;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    isa_clk_recovery u0 (
        .clk(clk), .rst_n(rst_n), .div_sel(div_sel),
        .rec8_code(rec8_code), .rec16_code(rec16_code),
        .cyc_done(cyc_done), .cyc_is_io(cyc_is_io), .cyc_wide(cyc_wide),
        .isa_clk_en(isa_clk_en), .io_grant(io_grant)
    );

    function automatic int exp_ratio(input logic [2:0] code);
        return (code == 3'b010) ? 3 : 4;
    endfunction

    function automatic int exp_gap(input logic [3:0] code);
        return int'(code) + 2;
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Cycles from one enable pulse to the next.
    task automatic measure_period(output int n);
        int w = 0;
        while (!isa_clk_en && w < 20) begin tick(); w++; end
        n = 0;
        do begin tick(); n++; end while (!isa_clk_en && n < 20);
    endtask

    // Report a completion, then count low-grant clocks.
    task automatic complete(input logic is_io, input logic wide, output int low);
        cyc_done = 1'b1; cyc_is_io = is_io; cyc_wide = wide;
        tick();
        cyc_done = 1'b0; cyc_is_io = 1'b0;
        low = 0;
        while (!io_grant && low < 40) begin low++; tick(); end
    endtask

    task automatic div_case(input logic [2:0] code, input string req);
        int p;
        div_sel = code;
        measure_period(p);
        measure_period(p);
        chk(req, p, exp_ratio(code));
    endtask

    initial begin
        int n;
        void'($urandom(32'd20240611));
        repeat (3) tick();
        // R1 reset state
        chk("R1 grant", int'(io_grant), 1);
        chk("R1 clk_en", int'(isa_clk_en), 0);
        rst_n = 1'b1;
        tick();

        // R2 R3 R4 directed and random divisor codes
        div_case(3'b010, "R2");
        div_case(3'b011, "R3");
        div_case(3'b000, "R4");
        div_case(3'b111, "R4");
        for (int i = 0; i < 8; i++) begin
            logic [2:0] c = 3'($urandom % 8);
            div_case(c, (c == 3'b010) ? "R2" : (c == 3'b011) ? "R3" : "R4");
        end
        // R5 no back-to-back enables over a stretch
        div_sel = 3'b010;
        for (int i = 0; i < 30; i++) begin
            logic prev = isa_clk_en;
            tick();
            if (prev) chk("R5", int'(isa_clk_en), 0);
        end

        // R8 extremes for both widths
        rec8_code = 4'h0; rec16_code = 4'hF;
        complete(1'b1, 1'b0, n); chk("R8 min 8-bit", n, 2);
        complete(1'b1, 1'b1, n); chk("R8 max 16-bit", n, 17);
        rec8_code = 4'hF; rec16_code = 4'h0;
        complete(1'b1, 1'b0, n); chk("R8 max 8-bit", n, 17);
        complete(1'b1, 1'b1, n); chk("R8 min 16-bit", n, 2);

        // R6 R7 random codes and widths
        for (int i = 0; i < 24; i++) begin
            logic w = 1'($urandom % 2);
            rec8_code = 4'($urandom % 16);
            rec16_code = 4'($urandom % 16);
            complete(1'b1, w, n);
            chk(w ? "R7" : "R6", n, exp_gap(w ? rec16_code : rec8_code));
            repeat (int'($urandom % 3)) tick();
        end

        // R9 non-I/O completion with grant high
        complete(1'b0, 1'b1, n);
        chk("R9 idle", n, 0);
        tick();
        chk("R9 idle hold", int'(io_grant), 1);
        // R9 non-I/O completion during a gap leaves its length alone
        rec8_code = 4'd5;
        cyc_done = 1'b1; cyc_is_io = 1'b1; cyc_wide = 1'b0;
        tick(); cyc_done = 1'b0; cyc_is_io = 1'b0;
        tick();
        complete(1'b0, 1'b1, n);
        chk("R9 gap", n + 2, exp_gap(4'd5));

        // R10 restart during a gap with the other width
        rec16_code = 4'd15; rec8_code = 4'd2;
        cyc_done = 1'b1; cyc_is_io = 1'b1; cyc_wide = 1'b1;
        tick(); cyc_done = 1'b0; cyc_is_io = 1'b0;
        repeat (3) tick();
        complete(1'b1, 1'b0, n);
        chk("R10", n, exp_gap(4'd2));

        // R11 grant stays high with no completion
        repeat (10) tick();
        chk("R11", int'(io_grant), 1);

        // R1 reset during a running gap
        rec16_code = 4'd15;
        cyc_done = 1'b1; cyc_is_io = 1'b1; cyc_wide = 1'b1;
        tick(); cyc_done = 1'b0; cyc_is_io = 1'b0;
        tick();
        rst_n = 1'b0;
        tick();
        chk("R1 mid-gap grant", int'(io_grant), 1);
        chk("R1 mid-gap clk_en", int'(isa_clk_en), 0);
        rst_n = 1'b1;
        tick();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule